// File: doc/BRIEF.md
# Head-Pointer Sharing-List Home Directory

This block is the home-side bookkeeping for a coherence scheme in which the sharers of a memory block form a chain that the caches maintain themselves. For every block it owns, the home stores only three things: a pointer to the first sharer in the chain, a flag saying whether the chain is empty, and a small state. That state records whether no remote copy exists, whether read-only copies exist with memory still valid, or whether a remote cache holds a writable copy.

Requesting nodes send read misses, write misses and roll-out notices. For a read or a write, the home reports who the previous head was and whether data comes from memory or from that previous head. It then makes the requester the new head, so the previous head becomes the requester's successor. A roll-out from the current head hands the head pointer to the successor that the notice carries. If there is no successor, the block goes back to the no-copy state.

Requests enter through a valid/ready stream and are handled one at a time, so all requests to any block are ordered by acceptance. A request is accepted only while `req_ready` is high. `req_ready` stays low from acceptance until the response has been taken. The response stream holds its payload unchanged while `rsp_valid` is high and `rsp_ready` is low.

Top module: `lld_home_dir`

## Requirements
- R1: After reset every block is in the no-copy state (state code 0) with an empty chain, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read (kind code 0) to a block in the no-copy state returns `rsp_old_head_valid`=0 and `rsp_from_mem`=1, and leaves the block shared-clean (state code 1). Across all responses, the prior state is the no-copy state exactly when no old head is reported.
- R3: A read to a shared-clean block returns the old head, takes data from memory and leaves the block shared-clean. A read to a block in the writable-remote state (state code 2) returns the old head, takes data from it (`rsp_from_mem`=0) and leaves the state unchanged.
- R4: A write (kind code 1) always leaves the block in state 2. Data comes from memory if the prior state was 0 or 1. If the prior state was 2, data comes from the old head, and the current owner's identity is still returned.
- R5: After a read or write, the requester is the block's head: the next request to that block reports it as old head.
- R6: A roll-out (kind code 2) from the current head carrying a successor (`req_succ_valid`=1) makes that successor the head, keeps the state and reports `rsp_applied`=1.
- R7: A roll-out from the current head with no successor empties the chain and returns the block to state 0.
- R8: A roll-out from a node that is not the head, a roll-out to an empty chain, or kind code 3 changes nothing and reports `rsp_applied`=0. The new state equals the prior state.
- R9: `req_ready` is low from the accepting edge until the edge where the response is taken, so only one request is ever in flight.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and every response field is unchanged.
- R11: `rsp_valid` rises on the first clock edge after the edge that accepts the request.
- R12: A request changes only the entry of the block it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 0 read, 1 write, 2 roll-out, 3 no operation |
| req_blk | input | $clog2(BLOCKS) | Block index |
| req_node | input | $clog2(NODES) | Requesting node |
| req_succ_valid | input | 1 | Roll-out carries a successor |
| req_succ | input | $clog2(NODES) | Successor identity for a roll-out |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | Echo of request kind |
| rsp_blk | output | $clog2(BLOCKS) | Echo of block index |
| rsp_node | output | $clog2(NODES) | Echo of requester |
| rsp_applied | output | 1 | Request changed or was served by the directory |
| rsp_from_mem | output | 1 | Data is supplied by home memory |
| rsp_old_head_valid | output | 1 | A previous head existed |
| rsp_old_head | output | $clog2(NODES) | Previous head identity |
| rsp_prev_state | output | 2 | Block state before the request |
| rsp_new_state | output | 2 | Block state after the request |

## Verification
A request accepted at one rising edge produces `rsp_valid` at the next rising edge. The bench therefore samples on falling edges and expects the response at exactly the second falling edge after acceptance; a response at any other falling edge fails the latency check. The block's state and head are only visible through the responses, so each scenario is confirmed by the prior-state and old-head fields of the next request to the same block. Back-pressure is tested by holding `rsp_ready` low for several falling edges. At each of those edges the bench checks that the payload is unchanged and that `req_ready` is low.

// File: rtl/lld_pkg.sv
package lld_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_ROLL  = 2'd2,
    K_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    S_HOME  = 2'd0,
    S_FRESH = 2'd1,
    S_GONE  = 2'd2
  } blk_state_e;
endpackage

// File: rtl/lld_store.sv
module lld_store
  import lld_pkg::*;
#(
  parameter int BLOCKS = 64,
  parameter int NW     = 4,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  output blk_state_e    rd_state,
  output logic          rd_hv,
  output logic [NW-1:0] rd_head,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  blk_state_e    wr_state,
  input  logic          wr_hv,
  input  logic [NW-1:0] wr_head
);
  blk_state_e          st_q   [BLOCKS];
  logic                hv_q   [BLOCKS];
  logic [NW-1:0]       head_q [BLOCKS];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_blk == BW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= S_HOME;
        hv_q[g]   <= 1'b0;
        head_q[g] <= '0;
      end else if (hit) begin
        st_q[g]   <= wr_state;
        hv_q[g]   <= wr_hv;
        head_q[g] <= wr_head;
      end
    end
  end

  assign rd_state = st_q[rd_blk];
  assign rd_hv    = hv_q[rd_blk];
  assign rd_head  = head_q[rd_blk];
endmodule

// File: rtl/lld_policy.sv
module lld_policy
  import lld_pkg::*;
#(
  parameter int NW = 4
) (
  input  req_kind_e     kind,
  input  logic [NW-1:0] node,
  input  logic          succ_valid,
  input  logic [NW-1:0] succ,
  input  blk_state_e    cur_state,
  input  logic          cur_hv,
  input  logic [NW-1:0] cur_head,
  output blk_state_e    nx_state,
  output logic          nx_hv,
  output logic [NW-1:0] nx_head,
  output logic          applied,
  output logic          from_mem,
  output logic          old_hv,
  output logic [NW-1:0] old_head
);
  logic is_head;
  assign is_head = cur_hv && (cur_head == node);

  always_comb begin
    nx_state = cur_state;
    nx_hv    = cur_hv;
    nx_head  = cur_head;
    applied  = 1'b0;
    from_mem = 1'b0;
    old_hv   = cur_hv;
    old_head = cur_head;
    unique case (kind)
      K_READ: begin
        applied  = 1'b1;
        nx_hv    = 1'b1;
        nx_head  = node;
        from_mem = (cur_state != S_GONE);
        nx_state = (cur_state == S_GONE) ? S_GONE : S_FRESH;
      end
      K_WRITE: begin
        applied  = 1'b1;
        nx_hv    = 1'b1;
        nx_head  = node;
        from_mem = (cur_state != S_GONE);
        nx_state = S_GONE;
      end
      K_ROLL: begin
        if (is_head) begin
          applied = 1'b1;
          if (succ_valid) begin
            nx_head = succ;
          end else begin
            nx_hv    = 1'b0;
            nx_head  = '0;
            nx_state = S_HOME;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lld_ctrl.sv
module lld_ctrl
  import lld_pkg::*;
#(
  parameter int NW = 4,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [BW-1:0] req_blk,
  input  logic [NW-1:0] req_node,
  input  logic          req_succ_valid,
  input  logic [NW-1:0] req_succ,
  output req_kind_e     q_kind,
  output logic [BW-1:0] q_blk,
  output logic [NW-1:0] q_node,
  output logic          q_sv,
  output logic [NW-1:0] q_succ,
  output logic          wr_en,
  input  blk_state_e    cur_state,
  input  blk_state_e    nx_state,
  input  logic          applied,
  input  logic          from_mem,
  input  logic          old_hv,
  input  logic [NW-1:0] old_head,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          r_applied,
  output logic          r_from_mem,
  output logic          r_old_hv,
  output logic [NW-1:0] r_old_head,
  output blk_state_e    r_prev,
  output blk_state_e    r_new
);
  typedef enum logic [1:0] {P_IDLE, P_LOOK, P_RESP} phase_e;
  phase_e ph_q;

  logic accept;
  assign req_ready = (ph_q == P_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_en     = (ph_q == P_LOOK);
  assign rsp_valid = (ph_q == P_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= P_IDLE;
    end else begin
      unique case (ph_q)
        P_IDLE:  if (accept) ph_q <= P_LOOK;
        P_LOOK:  ph_q <= P_RESP;
        P_RESP:  if (rsp_ready) ph_q <= P_IDLE;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_kind <= K_NONE;
      q_blk  <= '0;
      q_node <= '0;
      q_sv   <= 1'b0;
      q_succ <= '0;
    end else if (accept) begin
      q_kind <= req_kind_e'(req_kind);
      q_blk  <= req_blk;
      q_node <= req_node;
      q_sv   <= req_succ_valid;
      q_succ <= req_succ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_applied  <= 1'b0;
      r_from_mem <= 1'b0;
      r_old_hv   <= 1'b0;
      r_old_head <= '0;
      r_prev     <= S_HOME;
      r_new      <= S_HOME;
    end else if (ph_q == P_LOOK) begin
      r_applied  <= applied;
      r_from_mem <= from_mem;
      r_old_hv   <= old_hv;
      r_old_head <= old_head;
      r_prev     <= cur_state;
      r_new      <= nx_state;
    end
  end
endmodule

// File: rtl/lld_home_dir.sv
module lld_home_dir
  import lld_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int BLOCKS = 64,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [BW-1:0] req_blk,
  input  logic [NW-1:0] req_node,
  input  logic          req_succ_valid,
  input  logic [NW-1:0] req_succ,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_kind,
  output logic [BW-1:0] rsp_blk,
  output logic [NW-1:0] rsp_node,
  output logic          rsp_applied,
  output logic          rsp_from_mem,
  output logic          rsp_old_head_valid,
  output logic [NW-1:0] rsp_old_head,
  output logic [1:0]    rsp_prev_state,
  output logic [1:0]    rsp_new_state
);
  req_kind_e     q_kind;
  logic [BW-1:0] q_blk;
  logic [NW-1:0] q_node, q_succ;
  logic          q_sv, wr_en;
  blk_state_e    cur_state, nx_state, r_prev, r_new;
  logic          cur_hv, nx_hv, applied, from_mem, old_hv;
  logic [NW-1:0] cur_head, nx_head, old_head;

  lld_store #(.BLOCKS(BLOCKS), .NW(NW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_blk   (q_blk),
    .rd_state (cur_state),
    .rd_hv    (cur_hv),
    .rd_head  (cur_head),
    .wr_en    (wr_en),
    .wr_blk   (q_blk),
    .wr_state (nx_state),
    .wr_hv    (nx_hv),
    .wr_head  (nx_head)
  );

  lld_policy #(.NW(NW)) u_policy (
    .kind       (q_kind),
    .node       (q_node),
    .succ_valid (q_sv),
    .succ       (q_succ),
    .cur_state  (cur_state),
    .cur_hv     (cur_hv),
    .cur_head   (cur_head),
    .nx_state   (nx_state),
    .nx_hv      (nx_hv),
    .nx_head    (nx_head),
    .applied    (applied),
    .from_mem   (from_mem),
    .old_hv     (old_hv),
    .old_head   (old_head)
  );

  lld_ctrl #(.NW(NW), .BW(BW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_kind       (req_kind),
    .req_blk        (req_blk),
    .req_node       (req_node),
    .req_succ_valid (req_succ_valid),
    .req_succ       (req_succ),
    .q_kind         (q_kind),
    .q_blk          (q_blk),
    .q_node         (q_node),
    .q_sv           (q_sv),
    .q_succ         (q_succ),
    .wr_en          (wr_en),
    .cur_state      (cur_state),
    .nx_state       (nx_state),
    .applied        (applied),
    .from_mem       (from_mem),
    .old_hv         (old_hv),
    .old_head       (old_head),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .r_applied      (rsp_applied),
    .r_from_mem     (rsp_from_mem),
    .r_old_hv       (rsp_old_head_valid),
    .r_old_head     (rsp_old_head),
    .r_prev         (r_prev),
    .r_new          (r_new)
  );

  assign rsp_kind       = q_kind;
  assign rsp_blk        = q_blk;
  assign rsp_node       = q_node;
  assign rsp_prev_state = r_prev;
  assign rsp_new_state  = r_new;
endmodule

// File: rtl/lld_dir_chk.sv
module lld_dir_chk #(
  parameter int NW = 4,
  parameter int BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_kind,
  input logic [BW-1:0] rsp_blk,
  input logic [NW-1:0] rsp_node,
  input logic          rsp_applied,
  input logic          rsp_from_mem,
  input logic          rsp_old_head_valid,
  input logic [NW-1:0] rsp_old_head,
  input logic [1:0]    rsp_prev_state,
  input logic [1:0]    rsp_new_state
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_blk)
      && $stable(rsp_node) && $stable(rsp_applied) && $stable(rsp_from_mem)
      && $stable(rsp_old_head_valid) && $stable(rsp_old_head)
      && $stable(rsp_prev_state) && $stable(rsp_new_state)); // R10
  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !rsp_valid); // R11
  AST_RSP_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc, 2)); // R11
  AST_WRITE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd1 |-> rsp_new_state == 2'd2); // R4
  AST_EMPTY_IS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_prev_state == 2'd0) == !rsp_old_head_valid)); // R2
  AST_GONE_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_prev_state == 2'd2 |-> !rsp_from_mem); // R3
  AST_IDLE_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_applied |-> rsp_new_state == rsp_prev_state); // R8
endmodule

bind lld_home_dir lld_dir_chk #(.NW(NW), .BW(BW)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .req_valid          (req_valid),
  .req_ready          (req_ready),
  .rsp_valid          (rsp_valid),
  .rsp_ready          (rsp_ready),
  .rsp_kind           (rsp_kind),
  .rsp_blk            (rsp_blk),
  .rsp_node           (rsp_node),
  .rsp_applied        (rsp_applied),
  .rsp_from_mem       (rsp_from_mem),
  .rsp_old_head_valid (rsp_old_head_valid),
  .rsp_old_head       (rsp_old_head),
  .rsp_prev_state     (rsp_prev_state),
  .rsp_new_state      (rsp_new_state)
);

// File: tb/lld_home_dir_tb.sv
module lld_home_dir_tb;
  localparam int NODES = 16, BLOCKS = 64;
  localparam int NW = $clog2(NODES), BW = $clog2(BLOCKS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_succ_valid = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [BW-1:0] req_blk = '0;
  logic [NW-1:0] req_node = '0, req_succ = '0;
  logic req_ready, rsp_valid, rsp_applied, rsp_from_mem, rsp_old_head_valid;
  logic [1:0] rsp_kind, rsp_prev_state, rsp_new_state;
  logic [BW-1:0] rsp_blk;
  logic [NW-1:0] rsp_node, rsp_old_head;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  lld_home_dir #(.NODES(NODES), .BLOCKS(BLOCKS)) u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Issue one request; hold rsp_ready low for 'hold' falling edges once the response shows.
  task automatic send(input int kind, input int blk, input int node, input int sv,
                      input int succ, input int hold);
    int waitn;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_blk = BW'(blk);
    req_node = NW'(node); req_succ_valid = sv[0]; req_succ = NW'(succ);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waitn = 1;
    while (!rsp_valid && waitn < 20) begin
      @(negedge clk);
      waitn++;
    end
    chk("R11", "negedges until response", waitn, 2);
    chk("R9", "req_ready while response pending", int'(req_ready), 0);
    for (int i = 0; i < hold; i++) begin
      logic [15:0] snap;
      snap = {rsp_applied, rsp_from_mem, rsp_old_head_valid, rsp_old_head,
              rsp_prev_state, rsp_new_state, rsp_kind, 3'b0};
      @(negedge clk);
      chk("R10", "rsp_valid held", int'(rsp_valid), 1);
      chk("R10", "payload held", int'({rsp_applied, rsp_from_mem, rsp_old_head_valid,
          rsp_old_head, rsp_prev_state, rsp_new_state, rsp_kind, 3'b0}), int'(snap));
      chk("R9", "req_ready low under back-pressure", int'(req_ready), 0);
    end
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9", "req_ready after response taken", int'(req_ready), 1);
  endtask

  task automatic expect_rsp(input string req, input int app, input int mem, input int ohv,
                            input int oh, input int prev, input int nxt);
    chk(req, "applied", int'(rsp_applied), app);
    chk(req, "from_mem", int'(rsp_from_mem), mem);
    chk(req, "old_head_valid", int'(rsp_old_head_valid), ohv);
    if (ohv != 0) chk(req, "old_head", int'(rsp_old_head), oh);
    chk(req, "prev_state", int'(rsp_prev_state), prev);
    chk(req, "new_state", int'(rsp_new_state), nxt);
    take();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_read_chain();
    send(0, 5, 3, 0, 0, 0); expect_rsp("R2", 1, 1, 0, 0, 0, 1);
    send(0, 5, 7, 0, 0, 0); expect_rsp("R3_R5", 1, 1, 1, 3, 1, 1);
  endtask

  task automatic t_writes();
    send(1, 5, 9, 0, 0, 4); expect_rsp("R4_R5", 1, 1, 1, 7, 1, 2);
    send(1, 5, 2, 0, 0, 0); expect_rsp("R4", 1, 0, 1, 9, 2, 2);
    send(0, 5, 4, 0, 0, 0); expect_rsp("R3", 1, 0, 1, 2, 2, 2);
  endtask

  task automatic t_rollouts();
    send(2, 5, 2, 1, 9, 0); expect_rsp("R8", 0, 0, 1, 4, 2, 2);
    send(2, 5, 4, 1, 2, 0); expect_rsp("R6", 1, 0, 1, 4, 2, 2);
    send(0, 5, 6, 0, 0, 0); expect_rsp("R6", 1, 0, 1, 2, 2, 2);
    send(2, 5, 6, 0, 0, 0); expect_rsp("R7", 1, 0, 1, 6, 2, 0);
    send(0, 5, 1, 0, 0, 0); expect_rsp("R7", 1, 1, 0, 0, 0, 1);
    send(2, 10, 3, 0, 0, 0); expect_rsp("R8", 0, 0, 0, 0, 0, 0);
    send(3, 5, 1, 0, 0, 0); expect_rsp("R8", 0, 0, 1, 1, 1, 1);
  endtask

  task automatic t_isolation();
    send(1, 0, 5, 0, 0, 0); expect_rsp("R12", 1, 1, 0, 0, 0, 2);
    send(0, 63, 8, 0, 0, 0); expect_rsp("R12", 1, 1, 0, 0, 0, 1);
    send(0, 0, 11, 0, 0, 2); expect_rsp("R12", 1, 0, 1, 5, 2, 2);
    send(0, 5, 12, 0, 0, 0); expect_rsp("R12", 1, 1, 1, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_chain();
    t_writes();
    t_rollouts();
    t_isolation();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule